// File: doc/BRIEF.md
# Address Window Remapping Unit

This block turns request addresses from two independent sources, a processor port and a DMA port, into addresses in one of two destination spaces each. The processor port can reach DDR memory or PCI space; the DMA port can reach DDR memory or a local I/O bus. Every port owns four programmable windows. A window is described by a base, a mask and a map register. The mask selects which address bits must match the base. The map supplies the replacement upper bits and a destination code in its lowest bit.

Software reaches the twenty-four 64-bit window registers through a single-cycle register bus covering a 384-byte region. Writes land on the next clock edge; reads return the addressed register in the same cycle. Each request is translated from the current register contents and presented one clock later as a hit or miss flag, a one-hot destination select and the translated address. Out of reset, two processor windows give a boot map: the low 256 MiB go to DDR and the next 256 MiB go to PCI, both one-to-one.

Top module: `addr_window_remap`

## Requirements
- R1: After reset, processor window 0 has base 0, mask 0xFFFF_FFFF_F000_0000 and map 0. Processor window 1 has base 0x1000_0000, the same mask and map 0x1000_0001. Every other window register reads 0.
- R2: The register at byte offset G*0x20 + 8*W holds window W (0..3) of group G. Groups are 0 processor base, 1 processor mask, 2 processor map, 3 DMA base, 4 DMA mask and 5 DMA map. A write lands at the next rising edge, and all 64 bits read back. Bits [2:0] of the offset do not take part in register selection.
- R3: Offsets from 0xC0 to 0x1FF read as 0, and writes there leave every register unchanged.
- R4: A window takes part in matching only while bit 63 of its mask is 1. It matches when (addr & mask) == (base & mask).
- R5: When more than one window of a port matches, the lowest-numbered one is used.
- R6: On a hit, the translated address is (map & mask & ~1) | (addr & ~mask), taken from the winning window.
- R7: The select is 2'b01 (DDR) when bit 0 of the winning map is 0. It is 2'b10 when that bit is 1, meaning PCI on the processor port and local I/O on the DMA port.
- R8: On a miss, the miss flag is 1, the hit flag is 0, the select is 2'b00 and the translated address is 0.
- R9: A request presented with valid high produces its result one clock later, with the output valid high and exactly one of hit and miss set. Without valid, every output of that port is 0 in the next cycle.
- R10: Each port uses only its own windows. Programming DMA windows does not change processor results, and programming processor windows does not change DMA results.
- R11: With the reset configuration, processor addresses below 0x1000_0000 map unchanged to DDR, and 0x1000_0000 to 0x1FFF_FFFF map unchanged to PCI. The processor port misses from 0x2000_0000 upward, and every DMA request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data for cfg_addr, same cycle |
| cpu_vld | input | 1 | Processor request valid |
| cpu_addr | input | 64 | Processor request address |
| cpu_o_vld | output | 1 | Processor result valid |
| cpu_o_hit | output | 1 | Processor window hit |
| cpu_o_miss | output | 1 | Processor window miss |
| cpu_o_sel | output | 2 | Processor destination: 01 DDR, 10 PCI |
| cpu_o_addr | output | 64 | Processor translated address |
| dma_vld | input | 1 | DMA request valid |
| dma_addr | input | 64 | DMA request address |
| dma_o_vld | output | 1 | DMA result valid |
| dma_o_hit | output | 1 | DMA window hit |
| dma_o_miss | output | 1 | DMA window miss |
| dma_o_sel | output | 2 | DMA destination: 01 DDR, 10 local I/O |
| dma_o_addr | output | 64 | DMA translated address |

## Verification
The bench builds the block with the package defaults: 64-bit registers, four windows per port, a 384-byte region and a one-bit destination code. With these values the full range of window sizes, from 16 bytes to 2^39 bytes, can be programmed at random bases. The empty upper half of the register region can be probed as well. Directed sequences add overlapping windows with a lower window taking priority, disabled windows and the boot map. Random traffic then steers addresses both into programmed windows and across the whole 64-bit space.

// File: rtl/awr_pkg.sv
package awr_pkg;
    parameter int unsigned REG_W        = 64;
    parameter int unsigned NUM_WIN      = 4;
    parameter int unsigned NUM_GRP      = 6;
    parameter int unsigned REGION_BYTES = 384;
    parameter int unsigned CODE_W       = 1;
    parameter logic [REG_W-1:0] BOOT_SPAN = REG_W'(64'h1000_0000);

    localparam int unsigned WIN_BITS  = $clog2(NUM_WIN);
    localparam int unsigned CFG_AW    = $clog2(REGION_BYTES);
    localparam int unsigned BYTE_BITS = $clog2(REG_W / 8);
    localparam int unsigned DEF_BYTES = NUM_GRP * NUM_WIN * (REG_W / 8);
    localparam logic [REG_W-1:0] CODE_MASK = REG_W'((64'd1 << CODE_W) - 64'd1);

    localparam logic [1:0] SEL_DDR = 2'b01;
    localparam logic [1:0] SEL_ALT = 2'b10;

    // group order fixes the register offsets
    localparam int GRP_CPU_BASE = 0;
    localparam int GRP_CPU_MASK = 1;
    localparam int GRP_CPU_MAP  = 2;
    localparam int GRP_DMA_BASE = 3;
    localparam int GRP_DMA_MASK = 4;
    localparam int GRP_DMA_MAP  = 5;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] map;
    } win_t;

    typedef win_t [NUM_WIN-1:0] port_cfg_t;

    typedef struct packed {
        logic             hit;
        logic             miss;
        logic [1:0]       sel;
        logic [REG_W-1:0] addr;
    } res_t;

    function automatic port_cfg_t boot_cpu_cfg();
        port_cfg_t c;
        c = '0;
        c[0].base = '0;
        c[0].mask = ~(BOOT_SPAN - REG_W'(1));
        c[0].map  = '0;
        c[1].base = BOOT_SPAN;
        c[1].mask = ~(BOOT_SPAN - REG_W'(1));
        c[1].map  = BOOT_SPAN | REG_W'(1);
        return c;
    endfunction
endpackage

// File: rtl/awr_regfile.sv
module awr_regfile
    import awr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output port_cfg_t         cpu_cfg,
    output port_cfg_t         dma_cfg
);
    localparam int unsigned IDX_W = CFG_AW - BYTE_BITS;

    typedef struct packed {
        port_cfg_t cpu;
        port_cfg_t dma;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [IDX_W-1:0]          idx;
    logic [IDX_W-WIN_BITS-1:0] grp;
    logic [WIN_BITS-1:0]       win;
    logic                      in_def;

    assign idx    = cfg_addr[CFG_AW-1:BYTE_BITS];
    assign grp    = idx[IDX_W-1:WIN_BITS];
    assign win    = idx[WIN_BITS-1:0];
    assign in_def = cfg_addr < CFG_AW'(DEF_BYTES);

    always_comb begin
        bank_d    = bank_q;
        cfg_rdata = '0;
        if (in_def) begin
            case (int'(grp))
                GRP_CPU_BASE: begin
                    cfg_rdata = bank_q.cpu[win].base;
                    if (cfg_we) bank_d.cpu[win].base = cfg_wdata;
                end
                GRP_CPU_MASK: begin
                    cfg_rdata = bank_q.cpu[win].mask;
                    if (cfg_we) bank_d.cpu[win].mask = cfg_wdata;
                end
                GRP_CPU_MAP: begin
                    cfg_rdata = bank_q.cpu[win].map;
                    if (cfg_we) bank_d.cpu[win].map = cfg_wdata;
                end
                GRP_DMA_BASE: begin
                    cfg_rdata = bank_q.dma[win].base;
                    if (cfg_we) bank_d.dma[win].base = cfg_wdata;
                end
                GRP_DMA_MASK: begin
                    cfg_rdata = bank_q.dma[win].mask;
                    if (cfg_we) bank_d.dma[win].mask = cfg_wdata;
                end
                GRP_DMA_MAP: begin
                    cfg_rdata = bank_q.dma[win].map;
                    if (cfg_we) bank_d.dma[win].map = cfg_wdata;
                end
                default: cfg_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.cpu <= boot_cpu_cfg();
            bank_q.dma <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cpu_cfg = bank_q.cpu;
    assign dma_cfg = bank_q.dma;
endmodule

// File: rtl/awr_xlate.sv
module awr_xlate
    import awr_pkg::*;
(
    input  port_cfg_t        cfg,
    input  logic             vld,
    input  logic [REG_W-1:0] addr,
    output res_t             res
);
    logic [NUM_WIN-1:0] match;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign match[w] = cfg[w].mask[REG_W-1] &&
                          ((addr & cfg[w].mask) == (cfg[w].base & cfg[w].mask));
    end

    // scan downward so the lowest matching window is applied last
    always_comb begin
        res = '0;
        if (vld) begin
            res.miss = 1'b1;
            for (int w = NUM_WIN - 1; w >= 0; w--) begin
                if (match[w]) begin
                    res.hit  = 1'b1;
                    res.miss = 1'b0;
                    res.addr = (cfg[w].map & cfg[w].mask & ~CODE_MASK) |
                               (addr & ~cfg[w].mask);
                    res.sel  = (cfg[w].map[CODE_W-1:0] != '0) ? SEL_ALT : SEL_DDR;
                end
            end
        end
    end
endmodule

// File: rtl/addr_window_remap.sv
module addr_window_remap
    import awr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              cpu_vld,
    input  logic [REG_W-1:0]  cpu_addr,
    output logic              cpu_o_vld,
    output logic              cpu_o_hit,
    output logic              cpu_o_miss,
    output logic [1:0]        cpu_o_sel,
    output logic [REG_W-1:0]  cpu_o_addr,
    input  logic              dma_vld,
    input  logic [REG_W-1:0]  dma_addr,
    output logic              dma_o_vld,
    output logic              dma_o_hit,
    output logic              dma_o_miss,
    output logic [1:0]        dma_o_sel,
    output logic [REG_W-1:0]  dma_o_addr
);
    typedef struct packed {
        logic cpu_vld;
        res_t cpu;
        logic dma_vld;
        res_t dma;
    } out_t;

    port_cfg_t cpu_cfg, dma_cfg;
    res_t      cpu_res, dma_res;
    out_t      out_d, out_q;

    awr_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cpu_cfg   (cpu_cfg),
        .dma_cfg   (dma_cfg)
    );

    awr_xlate u_cpu_xl (
        .cfg  (cpu_cfg),
        .vld  (cpu_vld),
        .addr (cpu_addr),
        .res  (cpu_res)
    );

    awr_xlate u_dma_xl (
        .cfg  (dma_cfg),
        .vld  (dma_vld),
        .addr (dma_addr),
        .res  (dma_res)
    );

    always_comb begin
        out_d         = out_q;
        out_d.cpu_vld = cpu_vld;
        out_d.cpu     = cpu_res;
        out_d.dma_vld = dma_vld;
        out_d.dma     = dma_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cpu_o_vld  = out_q.cpu_vld;
    assign cpu_o_hit  = out_q.cpu.hit;
    assign cpu_o_miss = out_q.cpu.miss;
    assign cpu_o_sel  = out_q.cpu.sel;
    assign cpu_o_addr = out_q.cpu.addr;
    assign dma_o_vld  = out_q.dma_vld;
    assign dma_o_hit  = out_q.dma.hit;
    assign dma_o_miss = out_q.dma.miss;
    assign dma_o_sel  = out_q.dma.sel;
    assign dma_o_addr = out_q.dma.addr;
endmodule

// File: rtl/awr_checker.sv
module awr_checker
    import awr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [REG_W-1:0]  cfg_wdata,
    input logic [REG_W-1:0]  cfg_rdata,
    input logic              cpu_vld,
    input logic              cpu_o_vld,
    input logic              cpu_o_hit,
    input logic              cpu_o_miss,
    input logic [1:0]        cpu_o_sel,
    input logic [REG_W-1:0]  cpu_o_addr,
    input logic              dma_vld,
    input logic              dma_o_vld,
    input logic              dma_o_hit,
    input logic              dma_o_miss,
    input logic [1:0]        dma_o_sel,
    input logic [REG_W-1:0]  dma_o_addr
);
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && ($past(cfg_addr) < CFG_AW'(DEF_BYTES)) &&
         (cfg_addr[CFG_AW-1:BYTE_BITS] == $past(cfg_addr[CFG_AW-1:BYTE_BITS])))
        |-> (cfg_rdata == $past(cfg_wdata)));

    a_r3_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr >= CFG_AW'(DEF_BYTES)) |-> (cfg_rdata == '0));

    a_r7_cpu_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_o_hit |-> ($countones(cpu_o_sel) == 1));

    a_r7_dma_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        dma_o_hit |-> ($countones(dma_o_sel) == 1));

    a_r8_cpu_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_o_miss |-> (!cpu_o_hit && cpu_o_sel == 2'b00 && cpu_o_addr == '0));

    a_r8_dma_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        dma_o_miss |-> (!dma_o_hit && dma_o_sel == 2'b00 && dma_o_addr == '0));

    a_r9_cpu_latency: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_vld |=> (cpu_o_vld && (cpu_o_hit != cpu_o_miss)));

    a_r9_dma_latency: assert property (@(posedge clk) disable iff (!rst_n)
        dma_vld |=> (dma_o_vld && (dma_o_hit != dma_o_miss)));

    a_r9_cpu_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_vld |=> (!cpu_o_vld && !cpu_o_hit && !cpu_o_miss &&
                      cpu_o_sel == 2'b00 && cpu_o_addr == '0));

    a_r9_dma_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_vld |=> (!dma_o_vld && !dma_o_hit && !dma_o_miss &&
                      dma_o_sel == 2'b00 && dma_o_addr == '0));
endmodule

bind addr_window_remap awr_checker u_awr_checker (.*);

// File: tb/addr_window_remap_tb.sv
module addr_window_remap_tb_top;
    import awr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] M256 = 64'h1000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [63:0]       cfg_wdata = '0;
    logic [63:0]       cfg_rdata;
    logic              cpu_vld = 1'b0, dma_vld = 1'b0;
    logic [63:0]       cpu_addr = '0, dma_addr = '0;
    logic              cpu_o_vld, cpu_o_hit, cpu_o_miss;
    logic              dma_o_vld, dma_o_hit, dma_o_miss;
    logic [1:0]        cpu_o_sel, dma_o_sel;
    logic [63:0]       cpu_o_addr, dma_o_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // shadow of the window registers: [port][window], port 0 cpu, 1 dma
    logic [63:0] m_base [2][4];
    logic [63:0] m_mask [2][4];
    logic [63:0] m_map  [2][4];

    addr_window_remap dut_i (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [63:0] model_read(logic [CFG_AW-1:0] a);
        int g, w;
        if (a >= 9'h0C0) return 64'd0;
        g = int'(a) / 32;
        w = (int'(a) / 8) % 4;
        case (g)
            0: return m_base[0][w];
            1: return m_mask[0][w];
            2: return m_map[0][w];
            3: return m_base[1][w];
            4: return m_mask[1][w];
            default: return m_map[1][w];
        endcase
    endfunction

    function automatic res_t model_xlate(int p, logic [63:0] a);
        res_t r;
        r = '0;
        r.miss = 1'b1;
        for (int w = 0; w < 4; w++) begin
            if (m_mask[p][w][63] && ((a & m_mask[p][w]) == (m_base[p][w] & m_mask[p][w]))) begin
                r.hit  = 1'b1;
                r.miss = 1'b0;
                r.addr = (m_map[p][w] & m_mask[p][w] & ~64'd1) | (a & ~m_mask[p][w]);
                r.sel  = m_map[p][w][0] ? 2'b10 : 2'b01;
                break;
            end
        end
        return r;
    endfunction

    task automatic cfg_write(logic [CFG_AW-1:0] a, logic [63:0] d);
        int g, w;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        if (a < 9'h0C0) begin
            g = int'(a) / 32;
            w = (int'(a) / 8) % 4;
            case (g)
                0: m_base[0][w] = d;
                1: m_mask[0][w] = d;
                2: m_map[0][w]  = d;
                3: m_base[1][w] = d;
                4: m_mask[1][w] = d;
                default: m_map[1][w] = d;
            endcase
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_win(int p, int w, logic [63:0] b, logic [63:0] m, logic [63:0] mp);
        logic [CFG_AW-1:0] off;
        off = CFG_AW'(p * 96 + w * 8);
        cfg_write(off, b);
        cfg_write(off + 9'h020, m);
        cfg_write(off + 9'h040, mp);
    endtask

    task automatic read_chk(string tag, logic [CFG_AW-1:0] a);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, model_read(a));
    endtask

    task automatic xl_chk(string tag, logic [63:0] ca, logic [63:0] da);
        res_t ec, ed;
        ec = model_xlate(0, ca);
        ed = model_xlate(1, da);
        @(negedge clk);
        cpu_vld = 1'b1; cpu_addr = ca;
        dma_vld = 1'b1; dma_addr = da;
        @(negedge clk);
        cpu_vld = 1'b0; dma_vld = 1'b0;
        check({tag, " cpu R9 vld"}, 64'(cpu_o_vld), 64'd1);
        check({tag, " cpu R8 miss"}, 64'(cpu_o_miss), 64'(ec.miss));
        check({tag, " cpu R4 hit"}, 64'(cpu_o_hit), 64'(ec.hit));
        check({tag, " cpu R7 sel"}, 64'(cpu_o_sel), 64'(ec.sel));
        check({tag, " cpu R6 addr"}, cpu_o_addr, ec.addr);
        check({tag, " dma R9 vld"}, 64'(dma_o_vld), 64'd1);
        check({tag, " dma R8 miss"}, 64'(dma_o_miss), 64'(ed.miss));
        check({tag, " dma R4 hit"}, 64'(dma_o_hit), 64'(ed.hit));
        check({tag, " dma R7 sel"}, 64'(dma_o_sel), 64'(ed.sel));
        check({tag, " dma R6 addr"}, dma_o_addr, ed.addr);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7341));
        // R1 expected reset contents
        for (int p = 0; p < 2; p++)
            for (int w = 0; w < 4; w++) begin
                m_base[p][w] = '0; m_mask[p][w] = '0; m_map[p][w] = '0;
            end
        m_mask[0][0] = ~(M256 - 1);
        m_base[0][1] = M256;
        m_mask[0][1] = ~(M256 - 1);
        m_map[0][1]  = M256 | 64'd1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset register contents
        for (int a = 0; a < 192; a += 8) read_chk("R1 reset reg", CFG_AW'(a));
        check("R1 cpu win1 map literal", model_read(9'h048), 64'h1000_0001);

        // R9 idle outputs
        @(negedge clk);
        check("R9 idle cpu", {cpu_o_vld, cpu_o_hit, cpu_o_miss, cpu_o_sel, cpu_o_addr[58:0]}, 64'd0);
        check("R9 idle dma", {dma_o_vld, dma_o_hit, dma_o_miss, dma_o_sel, dma_o_addr[58:0]}, 64'd0);

        // R11 boot map
        xl_chk("R11 boot ddr", 64'h0800_1234, 64'h0000_0040);
        check("R11 ddr sel", 64'(cpu_o_sel), 64'd1);
        xl_chk("R11 boot pci", 64'h1ABC_0008, 64'h1ABC_0008);
        check("R11 pci sel", 64'(cpu_o_sel), 64'd2);
        xl_chk("R11 boot top", 64'h2000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R11 miss above 512M", 64'(cpu_o_miss), 64'd1);
        xl_chk("R11 boot edge", 64'h0FFF_FFFF, 64'h1FFF_FFFF);
        @(negedge clk);
        check("R9 idle after request", 64'(cpu_o_vld | dma_o_vld | cpu_o_hit | dma_o_miss), 64'd0);

        // R3 holes read zero, writes ignored
        cfg_write(9'h0C0, 64'hDEAD_BEEF_0000_0001);
        cfg_write(9'h178, 64'hFFFF_FFFF_FFFF_FFFF);
        cfg_write(9'h1F8, 64'h1234_5678_9ABC_DEF0);
        read_chk("R3 hole 0C0", 9'h0C0);
        check("R3 hole 0C0 zero", cfg_rdata, 64'd0);
        read_chk("R3 hole 178", 9'h178);
        read_chk("R3 hole 1F8", 9'h1F8);
        for (int a = 0; a < 192; a += 8) read_chk("R3 regs unchanged", CFG_AW'(a));

        // R2 write and readback, low offset bits ignored
        set_win(0, 2, 64'h4000_0000, ~(64'h4000_0000 - 1), 64'h4000_0001);
        read_chk("R2 cpu win2 base", 9'h010);
        read_chk("R2 cpu win2 mask", 9'h030);
        read_chk("R2 cpu win2 map", 9'h055);
        check("R2 map value", cfg_rdata, 64'h4000_0001);
        xl_chk("R2 cpu 1G-2G pci", 64'h7FFF_FFF0, 64'h0);

        // R6 R7 R10 dma windows remap, cpu untouched
        set_win(1, 0, 64'h8000_0000, ~(64'h0100_0000 - 1), 64'h2300_0000);
        set_win(1, 1, 64'h0000_00A0_0000_0000, ~(64'h1000 - 1), 64'h0000_0000_0005_0001);
        xl_chk("R6 dma ddr remap", 64'h8012_3456, 64'h8012_3456);
        check("R6 dma remap addr", dma_o_addr, 64'h2312_3456);
        check("R10 cpu still misses", 64'(cpu_o_miss), 64'd1);
        xl_chk("R7 dma lio", 64'h0800_0000, 64'h0000_00A0_0000_0ABC);
        check("R7 lio sel", 64'(dma_o_sel), 64'd2);
        check("R6 lio addr", dma_o_addr, 64'h0000_0000_0005_0ABC);

        // R4 disabled window
        cfg_write(9'h030, 64'h0);
        xl_chk("R4 disabled win2", 64'h5000_0000, 64'h0);
        check("R4 disabled miss", 64'(cpu_o_miss), 64'd1);

        // R5 overlap: win3 covers 0..4G
        set_win(0, 3, 64'h0, ~(64'h1_0000_0000 - 1), 64'h1_0000_0001);
        xl_chk("R5 win0 wins", 64'h0800_0000, 64'h0);
        check("R5 low win addr", cpu_o_addr, 64'h0800_0000);
        xl_chk("R5 win3 used", 64'h3000_0000, 64'h0);
        check("R5 win3 addr", cpu_o_addr, 64'h1_3000_0000);
        xl_chk("R10 dma unaffected", 64'h8012_3456, 64'h8012_3456);
        check("R10 dma addr", dma_o_addr, 64'h2312_3456);

        // random phase
        for (int it = 0; it < 400; it++) begin
            logic [63:0] ca, da, sz, mk;
            if (it % 8 == 0) begin
                int p, w, k;
                p = $urandom % 2;
                w = $urandom % 4;
                k = 4 + ($urandom % 36);
                sz = 64'd1 << k;
                mk = ($urandom % 8 == 0) ? 64'd0 : ~(sz - 1);
                set_win(p, w, rnd64() & mk, mk, (rnd64() & mk) | 64'($urandom % 2));
            end
            begin
                int wc, wd;
                wc = $urandom % 4;
                wd = $urandom % 4;
                ca = ($urandom % 2) ? rnd64()
                     : ((m_base[0][wc] & m_mask[0][wc]) | (rnd64() & ~m_mask[0][wc]));
                da = ($urandom % 2) ? rnd64()
                     : ((m_base[1][wd] & m_mask[1][wd]) | (rnd64() & ~m_mask[1][wd]));
            end
            xl_chk("R5 R6 random", ca, da);
            if (it % 16 == 0) read_chk("R2 random readback", CFG_AW'(($urandom % 24) * 8));
        end

        finish_run();
    end
endmodule